// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives 8-bit frames from a serial data line in clocked synchronous mode. The bit clock comes from one of two places. It can be an external serial clock input, which is synchronised into the system clock domain and sampled on its rising edges. It can also be a clock that the block divides down from the system clock and drives out to the sender. Bits arrive least significant first and go into a shift register. At each frame boundary they are handed to a receive data register, and a receive-full flag is set.

Software sees a register-style interface. It has a receive enable level, a clock-source select and an interrupt enable. Two write-one-to-clear strobes clear the full flag and the overrun flag. If a frame completes while the previous byte is still unclaimed, the new byte is dropped and the overrun flag is raised. While the overrun flag is set, reception is locked out and a transmit-inhibit output tells the transmit side to hold off. In internal clock mode the generated clock is gated: it parks high on overrun or when reception is disabled, and it restarts as soon as the overrun flag is cleared.

Top module: `sync_serial_rx`

## Requirements
- R1: With `int_clk_sel_i`=0, bits are sampled on rising edges of `sck_i` after synchronisation, `sck_oe_o` is 0 and `sck_o` stays 1.
- R2: With `int_clk_sel_i`=1, `rx_en_i`=1 and no overrun, `sck_oe_o` is 1. `sck_o` first falls HALF_DIV system cycles after enable, then toggles every HALF_DIV cycles, and each of its rising edges samples one bit.
- R3: The first received bit lands in bit 0 of `rdata_o` and the last in bit 7.
- R4: When a frame completes and `full_o` is 0, the frame is copied to `rdata_o` and `full_o` becomes 1.
- R5: When a frame completes and `full_o` is 1, `rdata_o` keeps its old value, `full_o` stays 1 and `ovr_o` becomes 1.
- R6: While `ovr_o` is 1, no bits are sampled, completed frames are neither loaded nor flagged, and `tx_inhibit_o` is 1. After the flags are cleared, the next frame is received from bit 0.
- R7: `rxi_o` is 1 exactly when `full_o` and `rie_i` are both 1. `eri_o` is 1 exactly when `ovr_o` and `rie_i` are both 1.
- R8: In internal mode `sck_o` parks at 1 while `ovr_o` is 1 or `rx_en_i` is 0, and toggling resumes once `ovr_o` is cleared.
- R9: Observing `rdata_o` does not clear `full_o`. `full_clr_i` and `ovr_clr_i` are one-cycle clear strobes. When a flag is set and cleared in the same cycle, it ends up set.
- R10: While `rx_en_i` is 0, clock edges are ignored and the bit counter is held at 0, so a partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| int_clk_sel_i | input | 1 | 1: generated clock, 0: external clock |
| rie_i | input | 1 | Receive interrupt enable |
| full_clr_i | input | 1 | Clear strobe for the full flag |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| sck_i | input | 1 | External serial clock |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Generated serial clock, idles high |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| rdata_o | output | DATA_W | Receive data register |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| rxi_o | output | 1 | Receive-end interrupt request |
| eri_o | output | 1 | Receive-error interrupt request |
| tx_inhibit_o | output | 1 | Transmit lockout while an error is flagged |

## Verification
The bench builds the block with HALF_DIV=4, SYNC_STAGES=2 and DATA_W=8. With a half period of four system cycles, the clock-gating checks run inside a few dozen cycles. These cover the exact first-fall delay, the low width, parking after overrun and restart after clear. The same setting keeps the generated edges well clear of the two-stage data synchroniser. The external-clock path is driven with a fixed edge-to-strobe latency. That fixed latency lets the bench place a clear strobe in the exact cycle a frame completes, which brings the set-wins case within reach.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= {STAGES{RST_VAL}};
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int unsigned HALF_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sck_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  // stopped clock parks high with the divider cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = run_i & wrap & ~sck_q;
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hold_i) begin
        cnt_q <= '0;
      end else if (stb_i) begin
        sh_q <= {bit_i, sh_q[DATA_W-1:1]};
        if (cnt_q == LAST_BIT) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              full_clr_i,
  input  logic              ovr_clr_i,
  input  logic              rie_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic [DATA_W-1:0] rdr_q;
  logic              full_q, ovr_q;
  logic              full_set, ovr_set;

  assign full_set = done_i & ~full_q;
  assign ovr_set  = done_i & full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (full_set) rdr_q <= data_i;
      // set beats clear
      full_q <= full_set | (full_q & ~full_clr_i);
      ovr_q  <= ovr_set  | (ovr_q  & ~ovr_clr_i);
    end
  end

  assign rdata_o = rdr_q;
  assign full_o  = full_q;
  assign ovr_o   = ovr_q;
  assign rxi_o   = full_q & rie_i;
  assign eri_o   = ovr_q & rie_i;
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import srx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HALF_DIV    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              int_clk_sel_i,
  input  logic              rie_i,
  input  logic              full_clr_i,
  input  logic              ovr_clr_i,
  input  logic              sck_i,
  input  logic              sd_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rxi_o,
  output logic              eri_o,
  output logic              tx_inhibit_o
);
  clk_src_e          src;
  logic              sck_s, sd_s, sck_prev_q;
  logic              ext_rise, int_rise, int_sck;
  logic              rx_live, run_int;
  logic              sample_stb;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;

  assign src = clk_src_e'(int_clk_sel_i);

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s)
  );

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sd_i), .q_o(sd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b1;
    else         sck_prev_q <= sck_s;
  end

  assign ext_rise = sck_s & ~sck_prev_q;

  // error lockout gates both the clock and sampling
  assign rx_live = rx_en_i & ~ovr_o;
  assign run_int = rx_live & (src == SRC_INT);

  srx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_int),
    .sck_o(int_sck), .rise_o(int_rise)
  );

  assign sample_stb = rx_live & ((src == SRC_INT) ? int_rise : ext_rise);

  srx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(~rx_en_i),
    .stb_i(sample_stb), .bit_i(sd_s),
    .done_o(frame_done), .data_o(frame_data)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .done_i(frame_done), .data_i(frame_data),
    .full_clr_i(full_clr_i), .ovr_clr_i(ovr_clr_i), .rie_i(rie_i),
    .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o),
    .rxi_o(rxi_o), .eri_o(eri_o)
  );

  assign sck_o        = (src == SRC_INT) ? int_sck : 1'b1;
  assign sck_oe_o     = (src == SRC_INT);
  assign tx_inhibit_o = ovr_o;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              int_clk_sel_i,
  input logic              full_clr_i,
  input logic              ovr_clr_i,
  input logic              sck_o,
  input logic              sck_oe_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              tx_inhibit_o,
  input logic              sample_stb,
  input logic              frame_done,
  input logic [DATA_W-1:0] frame_data
);
  assert_ext_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_sel_i |-> (sck_o && !sck_oe_o));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !full_o) |=> (full_o && rdata_o == $past(frame_data)));

  assert_overrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full_o) |=> (ovr_o && full_o && $stable(rdata_o)));

  assert_lockout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (!sample_stb && tx_inhibit_o));

  assert_clk_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clk_sel_i && (ovr_o || !rx_en_i)) |=> sck_o);

  assert_full_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !full_clr_i) |=> full_o);

  assert_ovr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

bind sync_serial_rx srx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i),
  .int_clk_sel_i(int_clk_sel_i), .full_clr_i(full_clr_i),
  .ovr_clr_i(ovr_clr_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
  .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o),
  .tx_inhibit_o(tx_inhibit_o), .sample_stb(sample_stb),
  .frame_done(frame_done), .frame_data(frame_data)
);

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb;
  localparam int unsigned DW   = 8;
  localparam int unsigned HALF = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en = 1'b0, int_sel = 1'b0, rie = 1'b0;
  logic full_clr = 1'b0, ovr_clr = 1'b0;
  logic sck_in = 1'b1, sd = 1'b0;
  logic sck_o, sck_oe_o, full_o, ovr_o, rxi_o, eri_o, tx_inh;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_serial_rx #(.DATA_W(DW), .HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en), .int_clk_sel_i(int_sel),
    .rie_i(rie), .full_clr_i(full_clr), .ovr_clr_i(ovr_clr),
    .sck_i(sck_in), .sd_i(sd), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .rdata_o(rdata), .full_o(full_o), .ovr_o(ovr_o), .rxi_o(rxi_o),
    .eri_o(eri_o), .tx_inhibit_o(tx_inh)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // external clock: data set while low, rising edge after 3 cycles
  task automatic ext_send(logic [DW-1:0] b, int nbits, bit clr_at_done);
    for (int i = 0; i < nbits; i++) begin
      sck_in = 1'b0;
      sd     = b[i];
      idle(3);
      sck_in = 1'b1;
      idle(3);
    end
    // now in the cycle where the frame-done pulse reaches the flags
    if (clr_at_done) begin
      full_clr = 1'b1;
      idle(1);
      full_clr = 1'b0;
    end
    idle(3);
  endtask

  task automatic pulse_clr(bit f, bit o);
    full_clr = f;
    ovr_clr  = o;
    idle(1);
    full_clr = 1'b0;
    ovr_clr  = 1'b0;
  endtask

  task automatic int_byte(logic [DW-1:0] b);
    for (int i = 0; i < DW; i++) begin
      @(negedge sck_o);
      @(negedge clk);
      sd = b[i];
      @(posedge sck_o);
    end
  endtask

  task automatic t_reset();
    check("R7 rxi reset", {31'b0, rxi_o}, 32'd0);
    check("R4 full reset", {31'b0, full_o}, 32'd0);
    check("R5 ovr reset", {31'b0, ovr_o}, 32'd0);
    check("R1 sck idle", {30'b0, sck_o, sck_oe_o}, 32'b10);
    check("R6 tx_inhibit reset", {31'b0, tx_inh}, 32'd0);
  endtask

  task automatic t_ext_basic();
    int_sel = 1'b0; rx_en = 1'b1; rie = 1'b1;
    idle(2);
    ext_send(8'hA5, 8, 1'b0);
    check("R4 full after frame", {31'b0, full_o}, 32'd1);
    check("R3 data A5", {24'b0, rdata}, 32'hA5);
    check("R7 rxi with rie", {31'b0, rxi_o}, 32'd1);
    check("R1 no clock drive", {30'b0, sck_o, sck_oe_o}, 32'b10);
    rie = 1'b0;
    idle(1);
    check("R7 rxi masked", {31'b0, rxi_o}, 32'd0);
    idle(4);
    check("R9 read keeps full", {31'b0, full_o}, 32'd1);
    pulse_clr(1'b1, 1'b0);
    check("R9 full cleared", {31'b0, full_o}, 32'd0);
  endtask

  task automatic t_ext_lsb();
    ext_send(8'h01, 8, 1'b0);
    check("R3 first bit to bit0", {24'b0, rdata}, 32'h01);
    pulse_clr(1'b1, 1'b0);
    ext_send(8'h80, 8, 1'b0);
    check("R3 last bit to bit7", {24'b0, rdata}, 32'h80);
    pulse_clr(1'b1, 1'b0);
  endtask

  task automatic t_overrun();
    rie = 1'b1;
    ext_send(8'h3C, 8, 1'b0);
    ext_send(8'hC3, 8, 1'b0);
    check("R5 ovr set", {31'b0, ovr_o}, 32'd1);
    check("R5 data kept", {24'b0, rdata}, 32'h3C);
    check("R5 full kept", {31'b0, full_o}, 32'd1);
    check("R7 eri", {31'b0, eri_o}, 32'd1);
    check("R6 tx inhibit", {31'b0, tx_inh}, 32'd1);
    pulse_clr(1'b1, 1'b0);
    ext_send(8'hFF, 8, 1'b0);
    check("R6 locked no load", {31'b0, full_o}, 32'd0);
    check("R6 locked data", {24'b0, rdata}, 32'h3C);
    pulse_clr(1'b0, 1'b1);
    check("R6 ovr cleared", {31'b0, ovr_o}, 32'd0);
    ext_send(8'h5A, 8, 1'b0);
    check("R6 resumes at bit0", {24'b0, rdata}, 32'h5A);
    pulse_clr(1'b1, 1'b0);
    rie = 1'b0;
  endtask

  task automatic t_partial();
    ext_send(8'hFF, 3, 1'b0);
    rx_en = 1'b0;
    idle(3);
    rx_en = 1'b1;
    idle(2);
    ext_send(8'h12, 8, 1'b0);
    check("R10 partial dropped", {24'b0, rdata}, 32'h12);
    pulse_clr(1'b1, 1'b0);
    rx_en = 1'b0;
    idle(2);
    ext_send(8'h77, 8, 1'b0);
    check("R10 disabled ignores edges", {31'b0, full_o}, 32'd0);
    rx_en = 1'b1;
    idle(2);
  endtask

  task automatic t_set_wins();
    ext_send(8'h69, 8, 1'b1);
    check("R9 set beats clear", {31'b0, full_o}, 32'd1);
    check("R9 data loaded", {24'b0, rdata}, 32'h69);
    pulse_clr(1'b1, 1'b0);
  endtask

  task automatic t_internal();
    int cnt;
    bit hi;
    rx_en = 1'b0;
    idle(2);
    int_sel = 1'b1;
    idle(1);
    check("R2 oe in int mode", {31'b0, sck_oe_o}, 32'd1);
    check("R8 parked while disabled", {31'b0, sck_o}, 32'd1);
    rx_en = 1'b1;
    cnt = 0;
    while (sck_o === 1'b1 && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    check("R2 first fall delay", cnt, HALF);
    cnt = 0;
    while (sck_o === 1'b0 && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    check("R2 low width", cnt, HALF);
    rx_en = 1'b0;
    hi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0 && sck_o !== 1'b1) hi = 1'b0;
    end
    check("R8 stops on disable", {31'b0, hi}, 32'd1);

    rie = 1'b1;
    rx_en = 1'b1;
    int_byte(8'hB4);
    int_byte(8'h4B);
    idle(3);
    check("R2 int frame data", {24'b0, rdata}, 32'hB4);
    check("R5 int overrun", {31'b0, ovr_o}, 32'd1);
    hi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sck_o !== 1'b1) hi = 1'b0;
    end
    check("R8 stops on overrun", {31'b0, hi}, 32'd1);
    pulse_clr(1'b1, 1'b1);
    int_byte(8'hE1);
    idle(3);
    check("R8 resumes after clear", {24'b0, rdata}, 32'hE1);
    check("R4 int full", {31'b0, full_o}, 32'd1);
    rx_en = 1'b0;
    idle(2);
    pulse_clr(1'b1, 1'b0);
    int_sel = 1'b0;
    rie = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    t_reset();
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_ext_basic();
    t_ext_lsb();
    t_overrun();
    t_partial();
    t_set_wins();
    t_internal();
    finish_run();
  end
endmodule